// File: doc/BRIEF.md
# Reduced 32-bit Integer Single-Cycle Core

This block is a single-cycle 32-bit processor that runs a pruned set of the RV32I base integer instructions, extended with a signed multiply and a signed divide. Every instruction completes in one clock: the program counter addresses an external instruction memory combinationally, the fetched word is decoded, operands are read from a 32-entry register file, the ALU or the next-PC logic produces a result, and on the rising edge the register file, the data memory and the program counter are updated together.

Memory traffic is limited to full 32-bit word loads and stores through a simple word-wide data port (address, write data, write enable, read enable, read data). Sub-word accesses, system, fence and control-register instructions are not implemented. They raise an illegal-instruction flag, leave the register file and data memory untouched, and fall through to the next word.

Top module: `core_top`

## Requirements
- R1: While `rst` is high the fetch address is `RESET_PC` (default 0) and no data-memory write or register write takes place; the first instruction executed after release is the word at `RESET_PC`.
- R2: Register-register operations (opcode 0110011, funct7 0000000 or 0100000) give ADD/SUB (funct3 000, instruction bit 30 selects subtract), XOR (100), OR (110), AND (111), SLL (001) and SRL/SRA (101, bit 30 selects arithmetic), with the shift amount taken from the low 5 bits of rs2.
- R3: SLT/SLTI compare signed and SLTU/SLTIU compare unsigned, writing 1 or 0; SLTIU sign-extends its 12-bit immediate before the unsigned compare.
- R4: ADDI, ANDI, ORI and XORI (opcode 0010011) combine rs1 with the sign-extended 12-bit immediate; SLLI, SRLI and SRAI shift by the 5-bit shamt field, bit 30 selecting arithmetic right shift.
- R5: LUI writes the 20-bit upper immediate shifted left by 12; AUIPC writes the address of the AUIPC instruction plus that shifted immediate.
- R6: With funct7 0000001, funct3 000 writes the low 32 bits of the signed product and funct3 100 writes the signed quotient truncated toward zero.
- R7: Division by zero writes 0xFFFFFFFF and 0x80000000 divided by -1 writes 0x80000000, without any trap.
- R8: LW (funct3 010) reads the word at rs1 plus the sign-extended offset into rd; SW (funct3 010) writes rs2 to that address in one cycle; read and write enable are never both high.
- R9: BEQ/BNE test equality, BLT/BGE compare signed, BLTU/BGEU compare unsigned; a taken branch adds the sign-extended offset to the PC, otherwise and for every other non-jump instruction the PC advances by 4.
- R10: JAL writes PC+4 to rd and jumps by the sign-extended offset; JALR jumps to rs1 plus the offset with bit 0 cleared and writes PC+4 to rd, using the old rs1 even when rd equals rs1.
- R11: Register x0 always reads as zero; writes to it are discarded.
- R12: Any unsupported encoding (unknown opcode, system or fence opcodes, sub-word load/store funct3, other multiply/divide funct3) raises `illegal` for that cycle, writes neither register nor memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (the current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| illegal | output | 1 | High while the current instruction is unsupported |

## Verification
The register-register group is run with two operand pairs: a negative rs1 against a small positive rs2 whose upper bits exceed the shift range, and a small positive rs1 against a negative rs2, so that signed and unsigned comparisons give opposite answers and a shifter that used more than five bits of rs2 would be caught. Multiply and divide are tried with mixed signs, a large product whose high half must be dropped, a zero divisor and the most-negative-by-minus-one case. Each branch kind is run with operands -1 and 1, where signed and unsigned ordering disagree, and the jump test uses a JALR whose destination register is also its base with bit 0 set in the target.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU, ALU_XOR,
    ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_MUL, ALU_DIV
  } alu_op_e;

  typedef enum logic [1:0] { SRCA_RS1, SRCA_PC, SRCA_ZERO } srca_e;

  typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_e;

  typedef struct packed {
    alu_op_e alu_op;
    srca_e   src_a;
    logic    src_b_imm;
    wb_e     wb_sel;
    logic    rf_we;
    logic    mem_re;
    logic    mem_we;
    logic    is_branch;
    logic    is_jal;
    logic    is_jalr;
    logic    illegal;
  } ctrl_t;

endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr1,
  input  logic [AW-1:0] raddr2,
  output logic [DW-1:0] rdata1,
  output logic [DW-1:0] rdata2
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Entry 0 is never written and is masked on read.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  assign rdata1 = (raddr1 == '0) ? '0 : mem[raddr1];
  assign rdata2 = (raddr2 == '0) ? '0 : mem[raddr2];

endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [31:0]       instr,
  output ctrl_t             ctrl,
  output logic [XLEN-1:0]   imm,
  output logic [REG_AW-1:0] rs1,
  output logic [REG_AW-1:0] rs2,
  output logic [REG_AW-1:0] rd,
  output logic [2:0]        funct3
);
  logic [6:0] opc, f7;
  logic       alt;

  assign opc    = instr[6:0];
  assign f7     = instr[31:25];
  assign alt    = instr[30];
  assign funct3 = instr[14:12];
  assign rs1    = instr[19:15];
  assign rs2    = instr[24:20];
  assign rd     = instr[11:7];

  // Immediate formats
  always_comb begin
    unique case (opc)
      OPC_STORE:           imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
      OPC_BRANCH:          imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25],
                                  instr[11:8], 1'b0};
      OPC_LUI, OPC_AUIPC:  imm = {instr[31:12], 12'b0};
      OPC_JAL:             imm = {{11{instr[31]}}, instr[31], instr[19:12], instr[20],
                                  instr[30:21], 1'b0};
      default:             imm = {{20{instr[31]}}, instr[31:20]};
    endcase
  end

  function automatic alu_op_e base_op(input logic [2:0] f3, input logic sub_ok,
                                      input logic alt_b);
    unique case (f3)
      3'b000:  return (sub_ok && alt_b) ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt_b ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    ctrl.src_a  = SRCA_RS1;
    ctrl.wb_sel = WB_ALU;
    unique case (opc)
      OPC_OP: begin
        ctrl.rf_we = 1'b1;
        if (f7 == 7'b0000001) begin
          ctrl.alu_op  = (funct3 == 3'b100) ? ALU_DIV : ALU_MUL;
          ctrl.illegal = !((funct3 == 3'b000) || (funct3 == 3'b100));
        end else begin
          ctrl.alu_op  = base_op(funct3, 1'b1, alt);
          ctrl.illegal = !((f7 == 7'b0000000) ||
                           ((f7 == 7'b0100000) && ((funct3 == 3'b000) || (funct3 == 3'b101))));
        end
      end
      OPC_OPIMM: begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.alu_op    = base_op(funct3, 1'b0, alt);
        if (funct3 == 3'b001)      ctrl.illegal = (f7 != 7'b0000000);
        else if (funct3 == 3'b101) ctrl.illegal = (f7 != 7'b0000000) && (f7 != 7'b0100000);
      end
      OPC_LOAD: begin
        ctrl.rf_we     = 1'b1;
        ctrl.mem_re    = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.wb_sel    = WB_MEM;
        ctrl.illegal   = (funct3 != 3'b010);
      end
      OPC_STORE: begin
        ctrl.mem_we    = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.illegal   = (funct3 != 3'b010);
      end
      OPC_BRANCH: begin
        ctrl.is_branch = 1'b1;
        ctrl.illegal   = (funct3 == 3'b010) || (funct3 == 3'b011);
      end
      OPC_JAL: begin
        ctrl.is_jal = 1'b1;
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_LINK;
      end
      OPC_JALR: begin
        ctrl.is_jalr = 1'b1;
        ctrl.rf_we   = 1'b1;
        ctrl.wb_sel  = WB_LINK;
        ctrl.illegal = (funct3 != 3'b000);
      end
      OPC_LUI: begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_a     = SRCA_ZERO;
        ctrl.src_b_imm = 1'b1;
      end
      OPC_AUIPC: begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_a     = SRCA_PC;
        ctrl.src_b_imm = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
    if (ctrl.illegal) begin
      ctrl.rf_we     = 1'b0;
      ctrl.mem_re    = 1'b0;
      ctrl.mem_we    = 1'b0;
      ctrl.is_branch = 1'b0;
      ctrl.is_jal    = 1'b0;
      ctrl.is_jalr   = 1'b0;
    end
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int SHW = $clog2(W);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [SHW-1:0] shamt;
  logic [W-1:0]   quot;

  assign shamt = b[SHW-1:0];

  // Signed divide with the two non-trapping special cases.
  always_comb begin
    if (b == '0)                          quot = '1;
    else if ((a == MOST_NEG) && (&b))     quot = MOST_NEG;
    else                                  quot = $signed(a) / $signed(b);
  end

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << shamt;
      ALU_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(W-1){1'b0}}, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = $signed(a) >>> shamt;
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      ALU_MUL:  y = a * b;   // low half is sign-independent
      ALU_DIV:  y = quot;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/core_nextpc.sv
module core_nextpc #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] rs1,
  input  logic [W-1:0] rs2,
  input  logic [W-1:0] imm,
  input  logic [2:0]   funct3,
  input  logic         is_branch,
  input  logic         is_jal,
  input  logic         is_jalr,
  output logic [W-1:0] link,
  output logic [W-1:0] next_pc
);
  logic taken;
  logic [W-1:0] jalr_tgt;

  always_comb begin
    unique case (funct3)
      3'b000:  taken = (rs1 == rs2);
      3'b001:  taken = (rs1 != rs2);
      3'b100:  taken = $signed(rs1) <  $signed(rs2);
      3'b101:  taken = $signed(rs1) >= $signed(rs2);
      3'b110:  taken = rs1 <  rs2;
      3'b111:  taken = rs1 >= rs2;
      default: taken = 1'b0;
    endcase
  end

  assign link     = pc + W'(4);
  assign jalr_tgt = (rs1 + imm) & ~W'(1);

  always_comb begin
    if (is_jalr)                       next_pc = jalr_tgt;
    else if (is_jal || (is_branch && taken)) next_pc = pc + imm;
    else                               next_pc = link;
  end

endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata,
  output logic        illegal
);
  ctrl_t             ctrl;
  logic [XLEN-1:0]   pc, imm, rs1_data, rs2_data, op_a, op_b, alu_y;
  logic [XLEN-1:0]   link, next_pc, wb_data;
  logic [REG_AW-1:0] rs1_addr, rs2_addr, rd_addr;
  logic [2:0]        funct3;
  logic              rf_we;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end

  core_decode u_dec (
    .instr(imem_data), .ctrl(ctrl), .imm(imm),
    .rs1(rs1_addr), .rs2(rs2_addr), .rd(rd_addr), .funct3(funct3)
  );

  core_regfile #(.DW(XLEN), .AW(REG_AW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rd_addr), .wdata(wb_data),
    .raddr1(rs1_addr), .raddr2(rs2_addr), .rdata1(rs1_data), .rdata2(rs2_data)
  );

  always_comb begin
    unique case (ctrl.src_a)
      SRCA_PC:   op_a = pc;
      SRCA_ZERO: op_a = '0;
      default:   op_a = rs1_data;
    endcase
  end
  assign op_b = ctrl.src_b_imm ? imm : rs2_data;

  core_alu #(.W(XLEN)) u_alu (.op(ctrl.alu_op), .a(op_a), .b(op_b), .y(alu_y));

  core_nextpc #(.W(XLEN)) u_npc (
    .pc(pc), .rs1(rs1_data), .rs2(rs2_data), .imm(imm), .funct3(funct3),
    .is_branch(ctrl.is_branch), .is_jal(ctrl.is_jal), .is_jalr(ctrl.is_jalr),
    .link(link), .next_pc(next_pc)
  );

  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wb_data = dmem_rdata;
      WB_LINK: wb_data = link;
      default: wb_data = alu_y;
    endcase
  end

  assign rf_we      = ctrl.rf_we & ~rst;
  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_data;
  assign dmem_we    = ctrl.mem_we & ~rst;
  assign dmem_re    = ctrl.mem_re & ~rst;
  assign illegal    = ctrl.illegal;

endmodule

// File: rtl/core_checker.sv
module core_checker
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       pc,
  input logic [6:0]        opcode,
  input logic              dmem_we,
  input logic              dmem_re,
  input logic              illegal,
  input logic              rf_we,
  input logic [REG_AW-1:0] rs1_addr,
  input logic [XLEN-1:0]   rs1_data
);
  logic ctl_flow;
  assign ctl_flow = (opcode == OPC_BRANCH) || (opcode == OPC_JAL) || (opcode == OPC_JALR);

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> (pc == RESET_PC));

  assert_mem_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctl_flow || illegal) |=> (pc == $past(pc) + 32'd4));

  assert_jalr_even_R10: assert property (@(posedge clk) disable iff (rst)
    ((opcode == OPC_JALR) && !illegal) |=> (pc[0] == 1'b0));

  assert_x0_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rs1_addr == '0) |-> (rs1_data == '0));

  assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we && !dmem_we && !dmem_re));

endmodule

bind core_top core_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .opcode(imem_data[6:0]),
  .dmem_we(dmem_we), .dmem_re(dmem_re), .illegal(illegal),
  .rf_we(rf_we), .rs1_addr(rs1_addr), .rs1_data(rs1_data)
);

// File: tb/core_top_tb.sv
module core_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re, illegal;

  logic [31:0] imem [128];
  logic [31:0] dmem [64];
  int n_chk = 0, n_err = 0, n_ill = 0, pi = 0;

  always #10 clk = ~clk;

  core_top u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .illegal(illegal)
  );

  assign imem_data  = imem[imem_addr[8:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  always @(negedge clk) if (!rst && illegal) n_ill <= n_ill + 1;

  // ---------- encoders ----------
  function automatic logic [31:0] r_t(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] i_t(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] s_t(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {im[11:5], rs2, rs1, f3, im[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] b_t(logic [12:0] im, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'h63};
  endfunction
  function automatic logic [31:0] j_t(logic [20:0] im, logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'h6f};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[pi] = w;
    pi++;
  endtask
  task automatic li(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) >> 12;
    emit({hi[19:0], rd, 7'h37});
    emit(i_t(v[11:0], rd, 3'b000, rd, 7'h13));
  endtask
  task automatic sw(input logic [4:0] rs2, input logic [11:0] off);
    emit(s_t(off, rs2, 5'd0, 3'b010));
  endtask

  task automatic new_prog();
    for (int i = 0; i < 128; i++) imem[i] = 32'h0000_006F;   // self-loop
    for (int i = 0; i < 64; i++)  dmem[i] = 32'hDEAD_BEEF;
    pi = 0;
  endtask

  task automatic run_prog();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (pi + 4) @(negedge clk);
  endtask

  function automatic logic [31:0] dm(input int off);
    return dmem[off / 4];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    new_prog();
    sw(5'd0, 12'h000);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc during reset", imem_addr, 32'h0);
    chk("R1 no store during reset", {31'b0, dmem_we}, 32'h0);
    chk("R1 memory untouched in reset", dm(0), 32'hDEAD_BEEF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first instruction executed", dm(0), 32'h0);
    chk("R1 pc after first step", imem_addr, 32'h4);
  endtask

  task automatic t_rr(input logic [31:0] a, input logic [31:0] b);
    logic [4:0] sh;
    sh = b[4:0];
    new_prog();
    li(5'd1, a); li(5'd2, b);
    emit(r_t(7'h00, 2, 1, 3'b000, 3)); sw(3, 12'h00);
    emit(r_t(7'h20, 2, 1, 3'b000, 3)); sw(3, 12'h04);
    emit(r_t(7'h00, 2, 1, 3'b001, 3)); sw(3, 12'h08);
    emit(r_t(7'h00, 2, 1, 3'b101, 3)); sw(3, 12'h0C);
    emit(r_t(7'h20, 2, 1, 3'b101, 3)); sw(3, 12'h10);
    emit(r_t(7'h00, 2, 1, 3'b100, 3)); sw(3, 12'h14);
    emit(r_t(7'h00, 2, 1, 3'b110, 3)); sw(3, 12'h18);
    emit(r_t(7'h00, 2, 1, 3'b111, 3)); sw(3, 12'h1C);
    emit(r_t(7'h00, 2, 1, 3'b010, 3)); sw(3, 12'h20);
    emit(r_t(7'h00, 2, 1, 3'b011, 3)); sw(3, 12'h24);
    run_prog();
    chk("R2 ADD", dm('h00), a + b);
    chk("R2 SUB", dm('h04), a - b);
    chk("R2 SLL", dm('h08), a << sh);
    chk("R2 SRL", dm('h0C), a >> sh);
    chk("R2 SRA", dm('h10), $signed(a) >>> sh);
    chk("R2 XOR", dm('h14), a ^ b);
    chk("R2 OR",  dm('h18), a | b);
    chk("R2 AND", dm('h1C), a & b);
    chk("R3 SLT",  dm('h20), {31'b0, $signed(a) < $signed(b)});
    chk("R3 SLTU", dm('h24), {31'b0, a < b});
  endtask

  task automatic t_imm();
    logic [31:0] a;
    a = 32'h8000_0F0F;
    new_prog();
    li(5'd1, a);
    emit(i_t(12'hFFB, 1, 3'b000, 3, 7'h13)); sw(3, 12'h00);
    emit(i_t(12'h0F0, 1, 3'b111, 3, 7'h13)); sw(3, 12'h04);
    emit(i_t(12'h800, 1, 3'b110, 3, 7'h13)); sw(3, 12'h08);
    emit(i_t(12'hFFF, 1, 3'b100, 3, 7'h13)); sw(3, 12'h0C);
    emit(i_t(12'hFFF, 1, 3'b010, 3, 7'h13)); sw(3, 12'h10);
    emit(i_t(12'hFFF, 1, 3'b011, 3, 7'h13)); sw(3, 12'h14);
    emit(i_t(12'h001, 1, 3'b011, 3, 7'h13)); sw(3, 12'h18);
    emit(i_t(12'h004, 1, 3'b001, 3, 7'h13)); sw(3, 12'h1C);
    emit(i_t(12'h004, 1, 3'b101, 3, 7'h13)); sw(3, 12'h20);
    emit(i_t(12'h404, 1, 3'b101, 3, 7'h13)); sw(3, 12'h24);
    run_prog();
    chk("R4 ADDI -5",    dm('h00), a - 32'd5);
    chk("R4 ANDI",       dm('h04), a & 32'h0F0);
    chk("R4 ORI sext",   dm('h08), a | 32'hFFFF_F800);
    chk("R4 XORI -1",    dm('h0C), ~a);
    chk("R3 SLTI -1",    dm('h10), 32'd1);
    chk("R3 SLTIU sext", dm('h14), 32'd1);
    chk("R3 SLTIU 1",    dm('h18), 32'd0);
    chk("R4 SLLI",       dm('h1C), a << 4);
    chk("R4 SRLI",       dm('h20), a >> 4);
    chk("R4 SRAI",       dm('h24), 32'hF800_00F0);
  endtask

  task automatic t_upper();
    logic [31:0] apc;
    new_prog();
    emit({20'hABCDE, 5'd3, 7'h37}); sw(3, 12'h00);
    apc = 32'(pi * 4);
    emit({20'h00001, 5'd4, 7'h17}); sw(4, 12'h04);
    run_prog();
    chk("R5 LUI",   dm('h00), 32'hABCD_E000);
    chk("R5 AUIPC", dm('h04), apc + 32'h1000);
  endtask

  function automatic logic [31:0] exp_div(input logic [31:0] a, input logic [31:0] b);
    if (b == 0) return 32'hFFFF_FFFF;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
    return $signed(a) / $signed(b);
  endfunction

  task automatic t_muldiv();
    logic [31:0] av [4], bv [4];
    logic [63:0] p;
    av = '{32'hFFFF_FFF9, 32'h1234_5678, 32'd100, 32'h8000_0000};
    bv = '{32'd3, 32'h0000_0100, 32'd0, 32'hFFFF_FFFF};
    new_prog();
    for (int k = 0; k < 4; k++) begin
      li(5'd1, av[k]); li(5'd2, bv[k]);
      emit(r_t(7'h01, 2, 1, 3'b000, 3)); sw(3, 12'(k * 8));
      emit(r_t(7'h01, 2, 1, 3'b100, 4)); sw(4, 12'(k * 8 + 4));
    end
    run_prog();
    for (int k = 0; k < 4; k++) begin
      p = $signed({{32{av[k][31]}}, av[k]}) * $signed({{32{bv[k][31]}}, bv[k]});
      chk("R6 MUL low word", dm(k * 8), p[31:0]);
      chk((k >= 2) ? "R7 DIV special case" : "R6 DIV", dm(k * 8 + 4), exp_div(av[k], bv[k]));
    end
  endtask

  task automatic t_mem();
    new_prog();
    dmem['h40 / 4] = 32'h55AA_33CC;
    li(5'd1, 32'h1234_ABCD);
    emit(i_t(12'h090, 0, 3'b000, 2, 7'h13));
    emit(s_t(12'hFF8, 1, 2, 3'b010));                 // sw x1,-8(x2) -> 0x88
    emit(i_t(12'hFF8, 2, 3'b010, 4, 7'h03));          // lw x4,-8(x2)
    emit(i_t(12'h001, 4, 3'b000, 4, 7'h13));
    sw(4, 12'h08C);
    emit(i_t(12'h040, 0, 3'b010, 5, 7'h03));
    sw(5, 12'h044);
    run_prog();
    chk("R8 SW negative offset", dm('h88), 32'h1234_ABCD);
    chk("R8 LW then use", dm('h8C), 32'h1234_ABCE);
    chk("R8 LW preset word", dm('h44), 32'h55AA_33CC);
  endtask

  task automatic t_branch();
    logic [2:0] f3 [7];
    logic [4:0] r2 [7];
    logic [31:0] ex [7];
    f3 = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111, 3'b000};
    r2 = '{5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd1};
    ex = '{32'd1, 32'd0, 32'd0, 32'd1, 32'd1, 32'd0, 32'd0};  // 0 = taken
    new_prog();
    li(5'd1, 32'hFFFF_FFFF); li(5'd2, 32'd1);
    for (int k = 0; k < 7; k++) begin
      emit(i_t(12'h000, 0, 3'b000, 3, 7'h13));
      emit(b_t(13'd8, r2[k], 1, f3[k]));
      emit(i_t(12'h001, 0, 3'b000, 3, 7'h13));
      sw(3, 12'(k * 4));
    end
    run_prog();
    for (int k = 0; k < 7; k++) chk($sformatf("R9 branch case %0d", k), dm(k * 4), ex[k]);
  endtask

  task automatic t_jump();
    logic [31:0] jal_pc, jalr_pc, tgt;
    new_prog();
    emit(i_t(12'h000, 0, 3'b000, 6, 7'h13));
    jal_pc = 32'(pi * 4);
    emit(j_t(21'd12, 5'd5));
    emit(i_t(12'h007, 0, 3'b000, 6, 7'h13));
    emit(i_t(12'h009, 0, 3'b000, 6, 7'h13));
    sw(5, 12'h00); sw(6, 12'h04);
    tgt = 32'((pi + 4) * 4);
    jalr_pc = tgt - 32'd8;
    li(5'd7, tgt - 32'd4 + 32'd1);
    emit(i_t(12'h004, 7, 3'b000, 7, 7'h67));       // jalr x7,4(x7)
    emit(i_t(12'h003, 0, 3'b000, 6, 7'h13));
    sw(7, 12'h08); sw(6, 12'h0C);
    run_prog();
    chk("R10 JAL link", dm('h00), jal_pc + 32'd4);
    chk("R10 JAL skipped body", dm('h04), 32'd0);
    chk("R10 JALR link rd==rs1", dm('h08), jalr_pc + 32'd4);
    chk("R10 JALR landed on even target", dm('h0C), 32'd0);
  endtask

  task automatic t_x0();
    new_prog();
    li(5'd1, 32'h77);
    emit(r_t(7'h00, 1, 1, 3'b000, 0));
    emit(i_t(12'h037, 0, 3'b000, 0, 7'h13));
    sw(0, 12'h10);
    emit(r_t(7'h00, 1, 0, 3'b000, 3));
    sw(3, 12'h14);
    run_prog();
    chk("R11 x0 still zero", dm('h10), 32'd0);
    chk("R11 x0 as operand", dm('h14), 32'h77);
  endtask

  task automatic t_illegal();
    int ill0;
    new_prog();
    emit(i_t(12'h005, 0, 3'b000, 1, 7'h13));
    emit(s_t(12'h020, 1, 0, 3'b000));            // byte store: unsupported
    emit(32'h0000_0073);                         // system opcode
    emit(32'h0000_000F);                         // fence opcode
    emit(r_t(7'h01, 1, 1, 3'b001, 1));           // high multiply: unsupported
    sw(1, 12'h024);
    ill0 = n_ill;
    run_prog();
    chk("R12 illegal cycles", 32'(n_ill - ill0), 32'd4);
    chk("R12 no store from illegal", dm('h20), 32'hDEAD_BEEF);
    chk("R12 no register write, fell through", dm('h24), 32'd5);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_rr(32'h8000_0F0F, 32'h0000_0023);
    t_rr(32'h0000_0005, 32'hFFFF_FFF0);
    t_imm();
    t_upper();
    t_muldiv();
    t_mem();
    t_branch();
    t_jump();
    t_x0();
    t_illegal();
    report();
  end

endmodule